// File: doc/BRIEF.md
# Interrupt Request Capture and Rotating Priority Resolver

This block keeps the request, mask, in-service and trigger-mode state of one eight-input interrupt controller. On every clock it decides whether an interrupt should be presented. Each input line is sampled on the clock. A per-line trigger-mode bit selects how the line is captured: a level-mode line follows its input, and an edge-mode line records a request only when it rises. Unmasked requests are scanned from a programmable priority base upward, wrapping modulo eight. The winner is raised only when it strictly outranks the highest line already in service.

The surrounding controller owns command decoding, cascading and vector generation. It drives this block through simple strobes. An acknowledge strobe moves the presented line into service. An end-of-service strobe retires one in-service line. Other strobes write the mask, the priority base and the trigger-mode byte, and a controller-clear strobe wipes everything except the trigger modes. A parameter sets the block's role, master or slave. On the master, an optional nesting mode leaves the cascade line (line 2) out of the in-service comparison.

Top module: `irq_resolver`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level mode) sets its request bit on every clock edge that samples the input high. It keeps that request after an acknowledge, so it is raised again once its service ends.
- R2: A line whose trigger-mode bit is 0 (edge mode) sets its request bit only on an edge where the input is high and the stored previous level is 0. A line held high after its request was cleared raises nothing new.
- R3: In either mode, an edge that samples the input low clears both the line's request bit and its stored previous level.
- R4: The pending set is the request bits with the mask bits removed (mask bit 1 = masked). A masked line never appears on `irqLine`.
- R5: The winner is the first pending line met when scanning from line `base` upward modulo 8. Its priority index is (line − base) mod 8, and index 0 is the highest priority.
- R6: `irqOut` is 1 only when the winner's priority index is strictly smaller than that of the highest-priority in-service line. An empty in-service set counts as index 8.
- R7: On a master instance with `sfnmEn` = 1, in-service bit 2 is ignored in the R6 comparison. On a slave instance, or with `sfnmEn` = 0, it counts.
- R8: A trigger-mode write stores `trigWrData` ANDed with a fixed keep mask, 0xF8 on a master and 0xDE on a slave. The result is visible on `trigMode`.
- R9: `ackEn` while `irqOut` = 1 sets the in-service bit of the line shown on `irqLine`. It clears that line's request only if the line is in edge mode.
- R10: `eoiEn` clears the in-service bit selected by `eoiLine`.
- R11: `ctlReset` clears the request, previous-level, mask, in-service and priority-base state, and leaves the trigger-mode register unchanged.
- R12: `irqOut` and `irqLine` are registered. They reflect the state one clock after that state changes, and `irqLine` is 0 whenever `irqOut` is 0.
- R13: The asynchronous reset `rstN` = 0 clears all state, including the trigger-mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlReset | input | 1 | Controller clear strobe; keeps trigger modes |
| irqIn | input | 8 | Interrupt input lines, sampled each clock |
| sfnmEn | input | 1 | Special nesting mode; cascade in-service bit ignored (master only) |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | 8 | New mask value, 1 = masked |
| baseWrEn | input | 1 | Priority base write strobe |
| baseWrData | input | 3 | Line that gets the highest priority |
| trigWrEn | input | 1 | Trigger-mode byte write strobe |
| trigWrData | input | 8 | New trigger modes, 1 = level |
| ackEn | input | 1 | Acknowledge the line shown on irqLine |
| eoiEn | input | 1 | End-of-service strobe |
| eoiLine | input | 3 | Line whose in-service bit is cleared |
| irqOut | output | 1 | Interrupt raised |
| irqLine | output | 3 | Winning line number |
| reqOut | output | 8 | Request register |
| isrOut | output | 8 | In-service register |
| trigMode | output | 8 | Trigger-mode register |

## Verification
Most of the state reaches the ports one or two clocks after it changes. A request bit captured wrongly shows on `reqOut` after the next edge. A wrong mask, base or in-service value shows on `irqOut`/`irqLine` one edge after that, because the resolver output is registered. A stale previous-level bit stays hidden until an edge-mode line is cleared while still held high, so the bench sets up exactly that case. The rotating scan and the strict in-service comparison are swept over every base, request pattern and pair of lines, so an off-by-one in the wrap or a non-strict compare gives a wrong winner within a few clocks.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  // strobes passed from the control side to the state datapath
  typedef struct packed {
    logic clearAll;
    logic maskWr;
    logic baseWr;
    logic trigWr;
    logic ackDo;
    logic eoiDo;
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int NUM_LINES = 8,
  localparam int IDXW = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] vec,
  input  logic [IDXW-1:0]      base,
  output logic [IDXW:0]        idx,
  output logic [IDXW-1:0]      line
);

  logic [NUM_LINES-1:0] rot;

  // rotate so that position 0 holds line 'base'; sum wraps at IDXW bits
  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : gRot
      assign rot[g] = vec[IDXW'(g) + base];
    end
  endgenerate

  always_comb begin
    idx = (IDXW+1)'(NUM_LINES);
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (rot[i]) idx = (IDXW+1)'(i);
    end
    line = idx[IDXW-1:0] + base;
  end

endmodule

// File: rtl/irq_res_ctrl.sv
module irq_res_ctrl
  import irq_res_pkg::*;
(
  input  logic         ctlReset,
  input  logic         maskWrEn,
  input  logic         baseWrEn,
  input  logic         trigWrEn,
  input  logic         ackEn,
  input  logic         eoiEn,
  input  logic         irqActive,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes.clearAll = ctlReset;
    strobes.maskWr   = maskWrEn & ~ctlReset;
    strobes.baseWr   = baseWrEn & ~ctlReset;
    strobes.trigWr   = trigWrEn;
    // an acknowledge only means something while a line is presented
    strobes.ackDo    = ackEn & irqActive & ~ctlReset;
    strobes.eoiDo    = eoiEn & ~ctlReset;
  end

endmodule

// File: rtl/irq_res_dpath.sv
module irq_res_dpath
  import irq_res_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter bit IS_MASTER = 1'b1,
  parameter logic [NUM_LINES-1:0] TRIG_KEEP = '1,
  parameter int CASCADE_LINE = 2,
  localparam int IDXW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 sfnmEn,
  input  logic [NUM_LINES-1:0] maskData,
  input  logic [IDXW-1:0]      baseData,
  input  logic [NUM_LINES-1:0] trigData,
  input  logic [IDXW-1:0]      eoiLine,
  output logic                 irqOut,
  output logic [IDXW-1:0]      irqLine,
  output logic [NUM_LINES-1:0] reqOut,
  output logic [NUM_LINES-1:0] isrOut,
  output logic [NUM_LINES-1:0] trigOut,
  output logic [NUM_LINES-1:0] pendOut
);

  localparam logic [NUM_LINES-1:0] CAS_BIT = NUM_LINES'(1) << CASCADE_LINE;

  logic [NUM_LINES-1:0] reqR, prevR, maskR, isrR, trigR;
  logic [NUM_LINES-1:0] reqN, prevN, maskN, isrN, trigN;
  logic [IDXW-1:0]      baseR, baseN;
  logic                 irqR;
  logic [IDXW-1:0]      lineR;

  logic [NUM_LINES-1:0] pendVec, svcVec;
  logic [IDXW:0]        pendIdx, svcIdx;
  logic [IDXW-1:0]      pendLine, svcLine;
  logic                 raise;

  // next-state of request capture, service and configuration
  always_comb begin
    reqN  = reqR;
    prevN = prevR;
    isrN  = isrR;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (irqIn[i]) begin
        if (trigR[i] || !prevR[i]) reqN[i] = 1'b1;
        prevN[i] = 1'b1;
      end else begin
        reqN[i]  = 1'b0;
        prevN[i] = 1'b0;
      end
    end
    if (strobes.ackDo) begin
      isrN[lineR] = 1'b1;
      if (!trigR[lineR]) reqN[lineR] = 1'b0;
    end
    if (strobes.eoiDo) isrN[eoiLine] = 1'b0;
    maskN = strobes.maskWr ? maskData : maskR;
    baseN = strobes.baseWr ? baseData : baseR;
    trigN = strobes.trigWr ? (trigData & TRIG_KEEP) : trigR;
    if (strobes.clearAll) begin
      reqN  = '0;
      prevN = '0;
      isrN  = '0;
      maskN = '0;
      baseN = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqR  <= '0;
      prevR <= '0;
      maskR <= '0;
      isrR  <= '0;
      trigR <= '0;
      baseR <= '0;
    end else begin
      reqR  <= reqN;
      prevR <= prevN;
      maskR <= maskN;
      isrR  <= isrN;
      trigR <= trigN;
      baseR <= baseN;
    end
  end

  assign pendVec = reqR & ~maskR;

  // only a master leaves the cascade line out of the service comparison
  generate
    if (IS_MASTER) begin : gMasterSvc
      assign svcVec = sfnmEn ? (isrR & ~CAS_BIT) : isrR;
    end else begin : gSlaveSvc
      assign svcVec = isrR;
    end
  endgenerate

  irq_prio_scan #(.NUM_LINES(NUM_LINES)) uPendScan (
    .vec  (pendVec),
    .base (baseR),
    .idx  (pendIdx),
    .line (pendLine)
  );

  irq_prio_scan #(.NUM_LINES(NUM_LINES)) uSvcScan (
    .vec  (svcVec),
    .base (baseR),
    .idx  (svcIdx),
    .line (svcLine)
  );

  assign raise = pendIdx < svcIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqR  <= 1'b0;
      lineR <= '0;
    end else begin
      irqR  <= raise;
      lineR <= raise ? pendLine : '0;
    end
  end

  assign irqOut  = irqR;
  assign irqLine = lineR;
  assign reqOut  = reqR;
  assign isrOut  = isrR;
  assign trigOut = trigR;
  assign pendOut = pendVec;

  logic unusedSvc;
  assign unusedSvc = ^svcLine;

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter bit IS_MASTER = 1'b1,
  parameter logic [NUM_LINES-1:0] MASTER_KEEP = NUM_LINES'('hF8),
  parameter logic [NUM_LINES-1:0] SLAVE_KEEP  = NUM_LINES'('hDE),
  parameter int CASCADE_LINE = 2,
  localparam int IDXW = $clog2(NUM_LINES),
  localparam logic [NUM_LINES-1:0] TRIG_KEEP = IS_MASTER ? MASTER_KEEP : SLAVE_KEEP
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctlReset,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 sfnmEn,
  input  logic                 maskWrEn,
  input  logic [NUM_LINES-1:0] maskWrData,
  input  logic                 baseWrEn,
  input  logic [IDXW-1:0]      baseWrData,
  input  logic                 trigWrEn,
  input  logic [NUM_LINES-1:0] trigWrData,
  input  logic                 ackEn,
  input  logic                 eoiEn,
  input  logic [IDXW-1:0]      eoiLine,
  output logic                 irqOut,
  output logic [IDXW-1:0]      irqLine,
  output logic [NUM_LINES-1:0] reqOut,
  output logic [NUM_LINES-1:0] isrOut,
  output logic [NUM_LINES-1:0] trigMode
);

  ctrlStrobes_t         strobes;
  logic [NUM_LINES-1:0] pendVec;

  irq_res_ctrl uCtrl (
    .ctlReset  (ctlReset),
    .maskWrEn  (maskWrEn),
    .baseWrEn  (baseWrEn),
    .trigWrEn  (trigWrEn),
    .ackEn     (ackEn),
    .eoiEn     (eoiEn),
    .irqActive (irqOut),
    .strobes   (strobes)
  );

  irq_res_dpath #(
    .NUM_LINES    (NUM_LINES),
    .IS_MASTER    (IS_MASTER),
    .TRIG_KEEP    (TRIG_KEEP),
    .CASCADE_LINE (CASCADE_LINE)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .irqIn    (irqIn),
    .sfnmEn   (sfnmEn),
    .maskData (maskWrData),
    .baseData (baseWrData),
    .trigData (trigWrData),
    .eoiLine  (eoiLine),
    .irqOut   (irqOut),
    .irqLine  (irqLine),
    .reqOut   (reqOut),
    .isrOut   (isrOut),
    .trigOut  (trigMode),
    .pendOut  (pendVec)
  );

endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] TRIG_KEEP = '1,
  localparam int IDXW = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ctlReset,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 trigWrEn,
  input logic [NUM_LINES-1:0] trigWrData,
  input logic                 ackEn,
  input logic                 eoiEn,
  input logic [IDXW-1:0]      eoiLine,
  input logic                 irqOut,
  input logic [IDXW-1:0]      irqLine,
  input logic [NUM_LINES-1:0] reqOut,
  input logic [NUM_LINES-1:0] isrOut,
  input logic [NUM_LINES-1:0] trigMode,
  input logic [NUM_LINES-1:0] pendVec
);

  logic [NUM_LINES-1:0] pendPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendPrev <= '0;
    else       pendPrev <= pendVec;
  end

  a_r1_level_sets: assert property (@(posedge clk) disable iff (!rstN)
    !ctlReset |=> ((reqOut & $past(trigMode & irqIn)) == $past(trigMode & irqIn)));

  a_r3_low_clears: assert property (@(posedge clk) disable iff (!rstN)
    !ctlReset |=> ((reqOut & $past(~irqIn)) == '0));

  a_r4_winner_pending: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> pendPrev[irqLine]);

  a_r8_trig_keep: assert property (@(posedge clk) disable iff (!rstN)
    trigWrEn |=> (trigMode == ($past(trigWrData) & TRIG_KEEP)));

  a_r9_ack_in_service: assert property (@(posedge clk) disable iff (!rstN)
    (ackEn && irqOut && !ctlReset && !eoiEn) |=> isrOut[$past(irqLine)]);

  a_r10_eoi_clears: assert property (@(posedge clk) disable iff (!rstN)
    (eoiEn && !ctlReset) |=> !isrOut[$past(eoiLine)]);

  a_r11_clear_state: assert property (@(posedge clk) disable iff (!rstN)
    ctlReset |=> (reqOut == '0 && isrOut == '0));

  a_r11_trig_kept: assert property (@(posedge clk) disable iff (!rstN)
    (ctlReset && !trigWrEn) |=> $stable(trigMode));

  a_r12_idle_line: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (irqLine == '0));

endmodule

bind irq_resolver irq_resolver_chk #(
  .NUM_LINES (NUM_LINES),
  .TRIG_KEEP (TRIG_KEEP)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .ctlReset   (ctlReset),
  .irqIn      (irqIn),
  .trigWrEn   (trigWrEn),
  .trigWrData (trigWrData),
  .ackEn      (ackEn),
  .eoiEn      (eoiEn),
  .eoiLine    (eoiLine),
  .irqOut     (irqOut),
  .irqLine    (irqLine),
  .reqOut     (reqOut),
  .isrOut     (isrOut),
  .trigMode   (trigMode),
  .pendVec    (pendVec)
);

// File: tb/irq_resolver_test.sv
`timescale 1ns/1ps
module irq_resolver_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic       ctlReset = 0, sfnmEn = 0, maskWrEn = 0, baseWrEn = 0, trigWrEn = 0;
  logic       ackEn = 0, eoiEn = 0;
  logic [7:0] irqIn = 0, maskWrData = 0, trigWrData = 0;
  logic [2:0] baseWrData = 0, eoiLine = 0;
  logic       irqOut;
  logic [2:0] irqLine;
  logic [7:0] reqOut, isrOut, trigMode;

  logic       sTrigWrEn = 0;
  logic [7:0] sTrigWrData = 0;
  logic       sIrqOut;
  logic [2:0] sIrqLine;
  logic [7:0] sReqOut, sIsrOut, sTrigMode;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  irq_resolver #(.IS_MASTER(1'b1)) uut (
    .clk(clk), .rstN(rstN), .ctlReset(ctlReset), .irqIn(irqIn), .sfnmEn(sfnmEn),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .trigWrEn(trigWrEn), .trigWrData(trigWrData),
    .ackEn(ackEn), .eoiEn(eoiEn), .eoiLine(eoiLine), .irqOut(irqOut),
    .irqLine(irqLine), .reqOut(reqOut), .isrOut(isrOut), .trigMode(trigMode)
  );

  irq_resolver #(.IS_MASTER(1'b0)) uutSlave (
    .clk(clk), .rstN(rstN), .ctlReset(1'b0), .irqIn(8'h00), .sfnmEn(1'b0),
    .maskWrEn(1'b0), .maskWrData(8'h00), .baseWrEn(1'b0), .baseWrData(3'd0),
    .trigWrEn(sTrigWrEn), .trigWrData(sTrigWrData), .ackEn(1'b0), .eoiEn(1'b0),
    .eoiLine(3'd0), .irqOut(sIrqOut), .irqLine(sIrqLine), .reqOut(sReqOut),
    .isrOut(sIsrOut), .trigMode(sTrigMode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wrMask(input logic [7:0] m);
    maskWrData = m; maskWrEn = 1; tick(); maskWrEn = 0;
  endtask

  task automatic wrBase(input logic [2:0] b);
    baseWrData = b; baseWrEn = 1; tick(); baseWrEn = 0;
  endtask

  task automatic wrTrig(input logic [7:0] t);
    trigWrData = t; trigWrEn = 1; tick(); trigWrEn = 0;
  endtask

  task automatic doAck();
    ackEn = 1; tick(); ackEn = 0;
  endtask

  task automatic doEoi(input logic [2:0] l);
    eoiLine = l; eoiEn = 1; tick(); eoiEn = 0;
  endtask

  // expected {irqOut, irqLine} when nothing is in service
  function automatic int expWin(input int p, input int b);
    for (int i = 0; i < 8; i++) begin
      if (((p >> ((b + i) & 7)) & 1) != 0) return 8 + ((b + i) & 7);
    end
    return 0;
  endfunction

  function automatic int prio(input int line, input int b);
    return (line - b) & 7;
  endfunction

  function automatic int outVal();
    return {28'd0, irqOut, irqLine};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // R13 reset state
    chk("R13 irqOut", int'(irqOut), 0);
    chk("R13 trigMode", int'(trigMode), 0);
    chk("R13 reqOut", int'(reqOut), 0);
    chk("R13 isrOut", int'(isrOut), 0);

    // R12 latency: request after one edge, interrupt after the next
    irqIn = 8'h10;
    tick();
    chk("R12 req after 1 edge", int'(reqOut), 'h10);
    chk("R12 irq not yet", int'(irqOut), 0);
    tick();
    chk("R12 irq after 2 edges", outVal(), 8 + 4);
    irqIn = 0; settle();
    chk("R12 idle line zero", outVal(), 0);

    // R8 keep masks
    wrTrig(8'hFF);
    sTrigWrData = 8'hFF; sTrigWrEn = 1; tick(); sTrigWrEn = 0;
    tick();
    chk("R8 master keep", int'(trigMode), 'hF8);
    chk("R8 slave keep", int'(sTrigMode), 'hDE);

    // R5 rotating scan sweep
    for (int b = 0; b < 8; b++) begin
      wrBase(3'(b));
      for (int p = 0; p < 256; p++) begin
        irqIn = 0; tick();
        irqIn = 8'(p); settle();
        chk($sformatf("R5 base %0d pattern %0h", b, p), outVal(), expWin(p, b));
      end
    end
    irqIn = 0; wrBase(3'd0); settle();

    // R4 mask sweep
    irqIn = 8'hFF;
    for (int m = 0; m < 256; m++) begin
      wrMask(8'(m)); settle();
      chk($sformatf("R4 mask %0h", m), outVal(), expWin((~m) & 'hFF, 0));
    end
    wrMask(8'h00); irqIn = 0; settle();

    // R6 nesting sweep (R9 and R10 on the way)
    for (int b = 0; b < 8; b++) begin
      wrBase(3'(b));
      for (int l = 0; l < 8; l++) begin
        for (int h = 0; h < 8; h++) begin
          if (h == l) continue;
          irqIn = 8'(1 << l); settle();
          doAck(); settle();
          chk("R9 ack sets in-service", int'(isrOut), 1 << l);
          irqIn = 8'((1 << l) | (1 << h)); settle();
          chk($sformatf("R6 base %0d svc %0d new %0d", b, l, h), outVal(),
              (prio(h, b) < prio(l, b)) ? (8 + h) : 0);
          irqIn = 0; tick();
          doEoi(3'(l)); settle();
          chk("R10 eoi clears", int'(isrOut), 0);
        end
      end
    end
    wrBase(3'd0); settle();

    // R1 level line keeps its request through service
    irqIn = 8'h20; settle();
    doAck(); settle();
    chk("R1 level request kept", int'(reqOut), 'h20);
    chk("R6 same line not raised", int'(irqOut), 0);
    doEoi(3'd5); settle();
    chk("R1 level re-raised", outVal(), 8 + 5);
    doAck(); irqIn = 0; settle(); doEoi(3'd5); settle();

    // R2 edge line
    irqIn = 8'h02; settle();
    chk("R2 rising sets", int'(reqOut), 'h02);
    doAck(); settle();
    chk("R9 edge request cleared", int'(reqOut), 0);
    doEoi(3'd1); settle();
    chk("R2 held high no request", int'(reqOut), 0);
    chk("R2 held high no irq", int'(irqOut), 0);
    irqIn = 0; tick(); irqIn = 8'h02; settle();
    chk("R2 new edge raises", outVal(), 8 + 1);
    irqIn = 0; settle();
    chk("R3 low clears request", int'(reqOut), 0);
    chk("R3 low drops irq", int'(irqOut), 0);

    // R7 special nesting on the master
    irqIn = 8'h04; settle();
    doAck(); settle();
    irqIn = 8'h24; settle();
    chk("R7 off cascade blocks", int'(irqOut), 0);
    sfnmEn = 1; settle();
    chk("R7 on lower line raised", outVal(), 8 + 5);
    irqIn = 8'h20; tick(); irqIn = 8'h24; settle();
    chk("R7 cascade line raised again", outVal(), 8 + 2);
    sfnmEn = 0; irqIn = 0; tick(); doEoi(3'd2); settle();
    chk("R10 cascade eoi", int'(isrOut), 0);

    // R11 controller clear
    wrMask(8'h01); wrBase(3'd3);
    irqIn = 8'h20; settle();
    doAck(); settle();
    ctlReset = 1; tick(); ctlReset = 0;
    chk("R11 in-service cleared", int'(isrOut), 0);
    chk("R11 trig kept", int'(trigMode), 'hF8);
    irqIn = 0; tick(); irqIn = 8'h21; settle();
    chk("R11 mask and base cleared", outVal(), 8 + 0);
    irqIn = 0; settle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule